// File: doc/BRIEF.md
# Configuration Base Address Decoder

This block holds the address-window configuration of a single configurable bus function. The function owns six general region registers and one expansion-ROM region register. Each region has a size fixed at build time (a power of two) and a fixed kind, I/O or memory. Software places a region by writing a base address into its register. The block clears the address bits below the region size, so software can write all ones, read the value back and learn the size. Two enable bits in the command word switch decoding of I/O space and of memory space on and off.

From the stored bases and the enables, the block works out at every cycle which regions are actually live. A region is live only when its space is enabled and its base is nonzero. Its end address must not wrap, and an I/O region must also stay inside the 64 KiB I/O space. The ROM region further needs its own enable bit. A probe address with a space flag is matched against the live regions. The block returns a one-hot hit vector, in which the lowest region index wins when windows overlap.

Configuration accesses use a byte offset and four byte-lane enables. Reads are combinational on the offset.

Top module: `bar_decoder`

## Requirements
- R1: After reset, every region register holds zero, both space enables are clear, `region_mapped` and `hit_vec` are all zero, and the command word reads 0. An I/O region register then reads 0x00000001.
- R2: A region register (general register n at byte offset 0x10+4n, ROM register at 0x30) is updated only by a write with `cfg_be` = 4'b1111. A write with any other lane pattern leaves its readback and its mapping unchanged.
- R3: A written base is ANDed with the complement of (size-1). Readback returns the stored value, and bit 0 reads 1 for an I/O region and 0 for a memory region. Writing 0xFFFFFFFF therefore reads back as ~(size-1), with bit 0 set for I/O.
- R4: The ROM register also keeps written bit 0 as its enable. The ROM region is live only when that bit is 1 and the memory enable is set.
- R5: The command word sits at offset 0x04. A write with `cfg_be[0]` = 1 loads bit 0 as the I/O enable and bit 1 as the memory enable. Readback shows them in bits 1:0. A write with `cfg_be[0]` = 0 leaves both enables unchanged.
- R6: An I/O region is live only when the I/O enable is set, its masked base is nonzero, and base+size-1 is above the base and below 0x10000.
- R7: A memory region is live only when the memory enable is set, its masked base is nonzero and base+size-1 does not wrap past 0xFFFFFFFF.
- R8: A change of the enables re-evaluates every region from the cycle after the command write, with no rewrite of the bases.
- R9: `hit_vec` bit i (bit 6 = ROM) is set only when region i is live, its kind matches `probe_io` (1 = I/O access), and `probe_addr` lies within base..base+size-1. At most one bit is set, and the lowest index wins on overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (bits 7:2 select the dword) |
| cfg_be | input | 4 | Byte-lane enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| probe_addr | input | 32 | Address to be decoded |
| probe_io | input | 1 | 1 = I/O access, 0 = memory access |
| region_mapped | output | 7 | Live flag per region, bit 6 = ROM |
| hit_vec | output | 7 | One-hot decode result, bit 6 = ROM |

## Verification
Sizing writes of all ones go to an I/O, a memory and the ROM register. They show that masking follows each region's own size and that the kind bit is inserted only for I/O. A fixed set of bases is then stepped through the four enable combinations. This separates the I/O gate from the memory gate and shows the zero-base and ROM-enable exclusions. Bases just past the 64 KiB limit and at the top of memory tell the I/O limit apart from the wrap check. Probes at region edges, in the wrong space and in overlapping windows show inclusive bounds, kind filtering and lowest-index priority.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int ADDR_W   = 32;
  localparam int DW_W     = 6;
  localparam logic [DW_W-1:0] CMD_DW  = 6'd1;   // byte offset 0x04
  localparam logic [DW_W-1:0] BAR_DW0 = 6'd4;   // byte offset 0x10
  localparam logic [DW_W-1:0] ROM_DW  = 6'd12;  // byte offset 0x30

  function automatic logic is_full_word(input logic [3:0] be);
    return be == 4'hF;
  endfunction
endpackage

// File: rtl/bar_cmd.sv
module bar_cmd
  import bar_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_bits,
  output logic            io_en,
  output logic            mem_en
);
  logic [1:0] en_d, en_q;

  always_comb begin
    en_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 2'b00;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

  assign io_en  = en_q[0];
  assign mem_en = en_q[1];
endmodule

// File: rtl/bar_slot.sv
module bar_slot
  import bar_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SIZE   = 32'h10,
  parameter bit                IS_IO  = 1'b0,
  parameter bit                IS_ROM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_io,
  output logic [ADDR_W-1:0] rd_val,
  output logic              mapped,
  output logic              match
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(SIZE - 32'd1);
  localparam logic [ADDR_W-1:0] KEEP_MASK  = IS_ROM ? (ALIGN_MASK | 32'd1) : ALIGN_MASK;

  logic [ADDR_W-1:0] base_d, base_q, dec_base;
  logic [ADDR_W:0]   end_addr;
  logic              no_wrap, space_ok;

  always_comb begin
    base_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= base_d;
    end
  end

  always_comb begin
    dec_base = base_q & ALIGN_MASK;
    end_addr = {1'b0, dec_base} + {1'b0, SIZE} - 33'd1;
    no_wrap  = !end_addr[ADDR_W] && (end_addr[ADDR_W-1:0] > dec_base);
  end

  generate
    if (IS_IO) begin : g_io
      assign space_ok = io_en && (end_addr < 33'h1_0000);
      assign rd_val   = base_q | 32'd1;
    end else if (IS_ROM) begin : g_rom
      assign space_ok = mem_en && base_q[0];
      assign rd_val   = base_q;
    end else begin : g_mem
      assign space_ok = mem_en;
      assign rd_val   = base_q;
    end
  endgenerate

  assign mapped = space_ok && (dec_base != '0) && no_wrap;
  assign match  = mapped && (probe_io == IS_IO) && ((probe_addr & ALIGN_MASK) == dec_base);
endmodule

// File: rtl/bar_prio.sv
module bar_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = req & (~req + N'(1));
  end
endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
  import bar_pkg::*;
#(
  parameter int                            NUM_BARS = 6,
  parameter logic [NUM_BARS-1:0][31:0]     BAR_SIZE = {32'h100, 32'h100, 32'h10_0000,
                                                      32'h8, 32'h1000, 32'h20},
  parameter logic [NUM_BARS-1:0]           BAR_IO   = 6'b010101,
  parameter logic [31:0]                   ROM_SIZE = 32'h8000,
  localparam int                           REGIONS  = NUM_BARS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [31:0]        probe_addr,
  input  logic               probe_io,
  output logic [REGIONS-1:0] region_mapped,
  output logic [REGIONS-1:0] hit_vec
);
  logic              rst_meta_n, rst_core_n;
  logic [DW_W-1:0]   dw;
  logic              full_wr, cmd_wr;
  logic              io_en, mem_en;
  logic [REGIONS-1:0] slot_wr, slot_match;
  logic [31:0]       slot_rd [REGIONS];

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  assign dw      = cfg_addr[7:2];
  assign full_wr = cfg_we && is_full_word(cfg_be);
  assign cmd_wr  = cfg_we && cfg_be[0] && (dw == CMD_DW);

  bar_cmd u_cmd (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (cmd_wr),
    .wr_bits(cfg_wdata[1:0]),
    .io_en  (io_en),
    .mem_en (mem_en)
  );

  genvar g;
  generate
    for (g = 0; g < REGIONS; g++) begin : g_slot
      localparam bit          SLOT_ROM  = (g == NUM_BARS);
      localparam logic [31:0] SLOT_SIZE = SLOT_ROM ? ROM_SIZE : BAR_SIZE[g % NUM_BARS];
      localparam bit          SLOT_IO   = SLOT_ROM ? 1'b0 : BAR_IO[g % NUM_BARS];
      localparam logic [DW_W-1:0] SLOT_DW = SLOT_ROM ? ROM_DW : DW_W'(BAR_DW0 + g);

      assign slot_wr[g] = full_wr && (dw == SLOT_DW);

      bar_slot #(
        .SIZE  (SLOT_SIZE),
        .IS_IO (SLOT_IO),
        .IS_ROM(SLOT_ROM)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .wr_en     (slot_wr[g]),
        .wr_data   (cfg_wdata),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .probe_addr(probe_addr),
        .probe_io  (probe_io),
        .rd_val    (slot_rd[g]),
        .mapped    (region_mapped[g]),
        .match     (slot_match[g])
      );
    end
  endgenerate

  bar_prio #(.N(REGIONS)) u_prio (
    .req  (slot_match),
    .grant(hit_vec)
  );

  always_comb begin
    cfg_rdata = '0;
    if (dw == CMD_DW) begin
      cfg_rdata = {30'd0, mem_en, io_en};
    end
    for (int i = 0; i < NUM_BARS; i++) begin
      if (dw == DW_W'(BAR_DW0 + i)) cfg_rdata = slot_rd[i];
    end
    if (dw == ROM_DW) begin
      cfg_rdata = slot_rd[NUM_BARS];
    end
  end
endmodule

// File: rtl/bar_decoder_chk.sv
module bar_decoder_chk #(
  parameter int REGIONS = 7,
  parameter int NUM_BARS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [7:0]         cfg_addr,
  input logic [3:0]         cfg_be,
  input logic [31:0]        cfg_wdata,
  input logic               io_en,
  input logic               mem_en,
  input logic [REGIONS-1:0] region_mapped,
  input logic [REGIONS-1:0] hit_vec
);
  logic region_off;
  assign region_off = (cfg_addr[7:2] >= 6'd4 && cfg_addr[7:2] < 6'(4 + NUM_BARS))
                      || cfg_addr[7:2] == 6'd12;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R9

  AST_HIT_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~region_mapped) == '0); // R9

  AST_NO_EN_NO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !mem_en) |-> region_mapped == '0); // R6

  AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be != 4'hF && region_off) |=> $stable(region_mapped)); // R2

  AST_CMD_OFF_UNMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be[0] && cfg_addr[7:2] == 6'd1 && cfg_wdata[1:0] == 2'b00)
    |=> region_mapped == '0); // R8
endmodule

bind bar_decoder bar_decoder_chk #(.REGIONS(REGIONS), .NUM_BARS(NUM_BARS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_be       (cfg_be),
  .cfg_wdata    (cfg_wdata),
  .io_en        (io_en),
  .mem_en       (mem_en),
  .region_mapped(region_mapped),
  .hit_vec      (hit_vec)
);

// File: tb/sim_bar_decoder.sv
`timescale 1ns/1ps
module sim_bar_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] probe_addr;
  logic        probe_io;
  logic [6:0]  region_mapped;
  logic [6:0]  hit_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bar_decoder u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic probe(input logic [31:0] a, input logic io, output logic [6:0] h);
    probe_addr = a; probe_io = io;
    #1 h = hit_vec;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [6:0]  h;
    chk("R1 mapped", 32'(region_mapped), 32'h0);
    rd(8'h04, v); chk("R1 cmd", v, 32'h0);
    rd(8'h10, v); chk("R1 io bar0", v, 32'h1);
    rd(8'h14, v); chk("R1 mem bar1", v, 32'h0);
    rd(8'h30, v); chk("R1 rom", v, 32'h0);
    probe(32'h0, 1'b1, h); chk("R1 hit", 32'(h), 32'h0);
  endtask

  task automatic t_sizing();
    logic [31:0] v;
    wr(8'h10, 4'hF, 32'hFFFF_FFFF); rd(8'h10, v); chk("R3 io size", v, 32'hFFFF_FFE1);
    wr(8'h14, 4'hF, 32'hFFFF_FFFF); rd(8'h14, v); chk("R3 mem size", v, 32'hFFFF_F000);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF); rd(8'h30, v); chk("R4 rom size", v, 32'hFFFF_8001);
    wr(8'h30, 4'hF, 32'hE000_0000); rd(8'h30, v); chk("R4 rom no en", v, 32'hE000_0000);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    wr(8'h14, 4'hF, 32'hF000_0000);
    wr(8'h14, 4'h3, 32'h0000_0000); rd(8'h14, v); chk("R2 half write", v, 32'hF000_0000);
    wr(8'h17, 4'h8, 32'h0000_0000); rd(8'h14, v); chk("R2 byte write", v, 32'hF000_0000);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    wr(8'h10, 4'hF, 32'h0000_C000);
    wr(8'h18, 4'hF, 32'h0000_C040);
    wr(8'h1C, 4'hF, 32'h0000_0000);
    wr(8'h20, 4'hF, 32'h0000_FF00);
    wr(8'h24, 4'hF, 32'h1234_5678);
    rd(8'h24, v); chk("R3 mem mask", v, 32'h1234_5600);
    chk("R8 no enable", 32'(region_mapped), 32'h00);
    wr(8'h04, 4'h1, 32'h1);
    rd(8'h04, v); chk("R5 cmd io", v, 32'h1);
    chk("R6 io only", 32'(region_mapped), 32'h15);
    wr(8'h04, 4'h2, 32'h3);
    rd(8'h04, v); chk("R5 lane0 off", v, 32'h1);
    wr(8'h04, 4'h1, 32'h2);
    chk("R7 mem only", 32'(region_mapped), 32'h22);
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R5 cmd both", v, 32'h3);
    chk("R8 both", 32'(region_mapped), 32'h37);
    wr(8'h30, 4'hF, 32'hE000_0001);
    chk("R4 rom enabled", 32'(region_mapped), 32'h77);
  endtask

  task automatic t_limits();
    wr(8'h20, 4'hF, 32'h0001_0000);
    chk("R6 io past 64k", 32'(region_mapped), 32'h67);
    wr(8'h20, 4'hF, 32'h0000_FF00);
    chk("R6 io at 64k end", 32'(region_mapped), 32'h77);
    wr(8'h1C, 4'hF, 32'hFFF0_0000);
    chk("R7 top of mem", 32'(region_mapped), 32'h7F);
    wr(8'h1C, 4'hF, 32'h000F_FFFF);
    chk("R7 zero after mask", 32'(region_mapped), 32'h77);
  endtask

  task automatic t_hits();
    logic [6:0] h;
    probe(32'h0000_C01F, 1'b1, h); chk("R9 io upper edge", 32'(h), 32'h01);
    probe(32'h0000_C000, 1'b1, h); chk("R9 io lower edge", 32'(h), 32'h01);
    probe(32'h0000_C020, 1'b1, h); chk("R9 io past end", 32'(h), 32'h00);
    probe(32'h0000_C047, 1'b1, h); chk("R9 io bar2", 32'(h), 32'h04);
    probe(32'h0000_C01F, 1'b0, h); chk("R9 wrong space", 32'(h), 32'h00);
    probe(32'hF000_0FFF, 1'b0, h); chk("R9 mem bar1", 32'(h), 32'h02);
    probe(32'hE000_7FFF, 1'b0, h); chk("R9 rom", 32'(h), 32'h40);
    wr(8'h24, 4'hF, 32'hF000_0000);
    probe(32'hF000_0010, 1'b0, h); chk("R9 overlap lowest", 32'(h), 32'h02);
    wr(8'h04, 4'h1, 32'h2);
    probe(32'h0000_C01F, 1'b1, h); chk("R8 io off hit", 32'(h), 32'h00);
    wr(8'h04, 4'h1, 32'h0);
    chk("R8 all off", 32'(region_mapped), 32'h00);
    probe(32'hF000_0010, 1'b0, h); chk("R9 no hit when off", 32'(h), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    probe_addr = '0; probe_io = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sizing();
    t_partial();
    t_enables();
    t_limits();
    t_hits();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule